// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block moves an 18-bit word between two ports, A and B, with a separate storage stage in each direction. A stage works in one of three ways. While its pass control is high it is transparent, and the far port follows the near port combinationally. While pass is low and the direction's strobe input is static, it holds its last captured word. A rising strobe edge, allowed by an active-low strobe enable, loads a new word.

Each direction has its own output-enable, pass, strobe and strobe-enable inputs. The two directions share nothing except the system clock and reset. The three-state drivers are modelled as a data bus plus a drive flag for each port, and the surrounding logic resolves them onto a shared wire. The block runs on one system clock `clk`. The strobe inputs are sampled on that clock and treated as synchronous signals, and an edge is a change from low to high between two consecutive samples.

Top module: `ubt_transceiver`

## Requirements
- R1: While `rst_n` is low, both stored words are cleared to zero. After reset, with pass low and no strobe edge, `b_out` and `a_out` read zero.
- R2: While a direction's pass input is high, its output equals its input in the same cycle, with no clock edge needed.
- R3: While pass is low and no strobe edge is seen, the stored word and the output keep their value whatever the input does.
- R4: With pass low and strobe enable low, a strobe that is sampled low at one `clk` edge and high at the next loads the input present at that second edge. The output shows the new word right after that edge.
- R5: While the strobe enable is high, rising strobe edges do not change the stored word. Lowering the enable while the strobe is already high does not load a word either.
- R6: When pass falls, the stage keeps the input word sampled at the last `clk` edge where pass was high.
- R7: Each drive flag is high exactly when that direction's active-low output enable is low, combinationally. The data bus carries the stage output whatever the flag is.
- R8: While the output enable is high, the stage still loads and passes words. Enabling the output then shows the latest stored word.
- R9: While pass is high, the strobe and strobe enable have no effect on the output.
- R10: The A-to-B stage (inputs `ab_*`, source `a_in`, result `b_out`/`b_drive`) and the B-to-A stage (inputs `ba_*`, source `b_in`, result `a_out`/`a_drive`) never affect each other, including when both are active at once.
- R11: A strobe that is high while reset is released does not count as a rising edge. A load needs the strobe to be sampled low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Word arriving on the A side |
| a_out | output | 18 | Word from the B-to-A stage, to be driven onto A |
| a_drive | output | 1 | High when `a_out` should be driven |
| b_in | input | 18 | Word arriving on the B side |
| b_out | output | 18 | Word from the A-to-B stage, to be driven onto B |
| b_drive | output | 1 | High when `b_out` should be driven |
| ab_out_en_n | input | 1 | Active-low output enable, A-to-B |
| ab_pass | input | 1 | Transparent control, A-to-B |
| ab_strobe | input | 1 | Load strobe, A-to-B |
| ab_strobe_en_n | input | 1 | Active-low strobe enable, A-to-B |
| ba_out_en_n | input | 1 | Active-low output enable, B-to-A |
| ba_pass | input | 1 | Transparent control, B-to-A |
| ba_strobe | input | 1 | Load strobe, B-to-A |
| ba_strobe_en_n | input | 1 | Active-low strobe enable, B-to-A |

## Verification
Transparent data and the drive flags are combinational. They are due in the same cycle, so the bench checks them a few nanoseconds after it changes an input, before the next clock edge. A strobe load takes effect at the first `clk` edge that samples the strobe high after a low sample, and the held value after a pass fall is the word sampled at the last edge with pass high. The bench therefore changes inputs one nanosecond after a rising edge and checks just before and just after the edge where the change is due. This shows that no result arrives a cycle early or late.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

   typedef struct packed {
      logic out_en_n;
      logic pass;
      logic strobe;
      logic strobe_en_n;
   } ubt_ctrl_t;

   localparam int unsigned UBT_DIRS = 2;
   localparam int unsigned DIR_AB   = 0;
   localparam int unsigned DIR_BA   = 1;

endpackage

// File: rtl/ubt_strobe_edge.sv
module ubt_strobe_edge #(
   parameter bit IDLE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic strobe_en_n,
   output logic load
);

   logic strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= IDLE_HIGH;
      else        strobe_q <= strobe;
   end

   assign load = strobe & ~strobe_q & ~strobe_en_n;

   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   // R11: a load needs the strobe to have been low on the previous sample
   p_edge_needs_low_r11: assert property (@(posedge clk) disable iff (!rst_n || !live)
      load |-> !$past(strobe));

endmodule

// File: rtl/ubt_hold_cell.sv
module ubt_hold_cell #(
   parameter int unsigned     WIDTH     = 18,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pass,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [WIDTH-1:0] held
);

   if (WIDTH < 1) begin : g_bad_width
      $error("ubt_hold_cell: WIDTH must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             held <= RESET_VAL;
      else if (pass || load)  held <= din;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign dout[i] = pass ? din[i] : held[i];
   end

   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n || !live)
      (!pass && !load) |=> $stable(held));

   p_load_takes_din_r4: assert property (@(posedge clk) disable iff (!rst_n || !live)
      (!pass && load) |=> (held == $past(din)));

   p_fall_keeps_last_r6: assert property (@(posedge clk) disable iff (!rst_n || !live)
      $fell(pass) |-> (held == $past(din)));

endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
   import ubt_pkg::*;
#(
   parameter int unsigned      WIDTH     = 18,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ubt_ctrl_t        ctrl,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             drive
);

   logic             load;
   logic [WIDTH-1:0] held;

   ubt_strobe_edge #(.IDLE_HIGH(1'b1)) u_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe      (ctrl.strobe),
      .strobe_en_n (ctrl.strobe_en_n),
      .load        (load)
   );

   ubt_hold_cell #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .pass  (ctrl.pass),
      .load  (load),
      .din   (din),
      .dout  (dout),
      .held  (held)
   );

   assign drive = ~ctrl.out_en_n;

   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   p_enable_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n || !live)
      (!ctrl.pass && ctrl.strobe_en_n) |=> $stable(held));

   p_updates_while_off_r8: assert property (@(posedge clk) disable iff (!rst_n || !live)
      (ctrl.out_en_n && ctrl.pass) |=> (held == $past(din)));

endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
   import ubt_pkg::*;
#(
   parameter int unsigned WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drive,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_drive,
   input  logic             ab_out_en_n,
   input  logic             ab_pass,
   input  logic             ab_strobe,
   input  logic             ab_strobe_en_n,
   input  logic             ba_out_en_n,
   input  logic             ba_pass,
   input  logic             ba_strobe,
   input  logic             ba_strobe_en_n
);

   if (WIDTH < 1) begin : g_bad_width
      $error("ubt_transceiver: WIDTH must be at least 1");
   end

   ubt_ctrl_t        ctrl [UBT_DIRS];
   logic [WIDTH-1:0] src  [UBT_DIRS];
   logic [WIDTH-1:0] dst  [UBT_DIRS];
   logic             drv  [UBT_DIRS];

   assign ctrl[DIR_AB] = '{out_en_n: ab_out_en_n, pass: ab_pass,
                           strobe: ab_strobe, strobe_en_n: ab_strobe_en_n};
   assign ctrl[DIR_BA] = '{out_en_n: ba_out_en_n, pass: ba_pass,
                           strobe: ba_strobe, strobe_en_n: ba_strobe_en_n};
   assign src[DIR_AB] = a_in;
   assign src[DIR_BA] = b_in;

   for (genvar d = 0; d < UBT_DIRS; d++) begin : g_dir
      ubt_lane #(.WIDTH(WIDTH), .RESET_VAL('0)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .ctrl  (ctrl[d]),
         .din   (src[d]),
         .dout  (dst[d]),
         .drive (drv[d])
      );
   end

   assign b_out   = dst[DIR_AB];
   assign b_drive = drv[DIR_AB];
   assign a_out   = dst[DIR_BA];
   assign a_drive = drv[DIR_BA];

   // R7: drive flag reacts to the enable within the same sample
   p_drive_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ab_out_en_n) |-> b_drive);

endmodule

// File: tb/tb_ubt_transceiver.sv
module tb_ubt_transceiver;

   localparam int W = 18;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic         a_drive, b_drive;
   logic         ab_out_en_n = 1'b1, ab_pass = 1'b0, ab_strobe = 1'b1, ab_strobe_en_n = 1'b0;
   logic         ba_out_en_n = 1'b1, ba_pass = 1'b0, ba_strobe = 1'b1, ba_strobe_en_n = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   ubt_transceiver #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n),
      .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
      .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
      .ab_out_en_n(ab_out_en_n), .ab_pass(ab_pass),
      .ab_strobe(ab_strobe), .ab_strobe_en_n(ab_strobe_en_n),
      .ba_out_en_n(ba_out_en_n), .ba_pass(ba_pass),
      .ba_strobe(ba_strobe), .ba_strobe_en_n(ba_strobe_en_n)
   );

   wire [W-1:0] b_bus = b_drive ? b_out : {W{1'bz}};

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      a_in = 18'h2A5A5; b_in = 18'h15A5A;
      rst_n = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(2);
      chk("R1 b_out after reset", b_out, '0);
      chk("R1 a_out after reset", a_out, '0);
      chk("R11 no load from high strobe at release", b_out, '0);
      chk("R7 b_drive off", {17'b0, b_drive}, 18'd0);
   endtask

   task automatic t_drive();
      ab_out_en_n = 1'b0; #1;
      chk("R7 b_drive on", {17'b0, b_drive}, 18'd1);
      chk("R10 a_drive unaffected", {17'b0, a_drive}, 18'd0);
      chk("R7 bus resolves", b_bus, '0);
   endtask

   task automatic t_transparent();
      ab_pass = 1'b1; a_in = 18'h0C3C3; #1;
      chk("R2 follows input", b_out, 18'h0C3C3);
      a_in = 18'h3F00F; #1;
      chk("R2 follows change", b_out, 18'h3F00F);
      step();
      ab_pass = 1'b0; a_in = 18'h11111; #1;
      chk("R6 keeps last sampled word", b_out, 18'h3F00F);
      step(3);
      chk("R3 holds after fall", b_out, 18'h3F00F);
   endtask

   task automatic t_load();
      ab_strobe = 1'b0; step();
      ab_strobe = 1'b1; a_in = 18'h24924; #1;
      chk("R4 not before edge", b_out, 18'h3F00F);
      step();
      chk("R4 loaded at edge", b_out, 18'h24924);
      a_in = 18'h01234; step(2);
      chk("R3 static high strobe holds", b_out, 18'h24924);
   endtask

   task automatic t_enable();
      ab_strobe = 1'b0; step();
      ab_strobe_en_n = 1'b1; ab_strobe = 1'b1; a_in = 18'h0BEEF; step();
      chk("R5 edge suppressed", b_out, 18'h24924);
      ab_strobe_en_n = 1'b0; step();
      chk("R5 late enable does not load", b_out, 18'h24924);
   endtask

   task automatic t_pass_ignores();
      ab_pass = 1'b1; a_in = 18'h30303;
      ab_strobe = 1'b0; step();
      ab_strobe = 1'b1; ab_strobe_en_n = 1'b1; step();
      chk("R9 strobe no effect while passing", b_out, 18'h30303);
      a_in = 18'h0F0F0; #1;
      chk("R9 still transparent", b_out, 18'h0F0F0);
      step();
      ab_pass = 1'b0; ab_strobe_en_n = 1'b0; ab_strobe = 1'b0; #1;
      chk("R6 held after pass drop", b_out, 18'h0F0F0);
   endtask

   task automatic t_off_updates();
      ab_out_en_n = 1'b1; step();
      a_in = 18'h1ABCD; ab_strobe = 1'b1; step();
      chk("R8 drive off", {17'b0, b_drive}, 18'd0);
      chk("R8 loaded while off", b_out, 18'h1ABCD);
      ab_out_en_n = 1'b0; #1;
      chk("R8 latest word shown", b_bus, 18'h1ABCD);
   endtask

   task automatic t_reverse_and_both();
      ba_out_en_n = 1'b0; ba_pass = 1'b1; b_in = 18'h2DEAD; #1;
      chk("R10 a_out transparent", a_out, 18'h2DEAD);
      chk("R10 a_drive on", {17'b0, a_drive}, 18'd1);
      chk("R10 b_out untouched", b_out, 18'h1ABCD);
      step();
      ba_pass = 1'b0; ba_strobe = 1'b0; b_in = 18'h05555; step();
      chk("R3 reverse holds", a_out, 18'h2DEAD);
      ba_strobe = 1'b1; step();
      chk("R4 reverse load", a_out, 18'h05555);
      chk("R10 b_out after reverse load", b_out, 18'h1ABCD);
      ab_pass = 1'b1; ba_pass = 1'b1; a_in = 18'h00F0F; b_in = 18'h3C003; #1;
      chk("R10 both pass a->b", b_out, 18'h00F0F);
      chk("R10 both pass b->a", a_out, 18'h3C003);
      step();
      ab_pass = 1'b0; ba_pass = 1'b0; a_in = 18'h0; b_in = 18'h3FFFF; step();
      chk("R6 both held b_out", b_out, 18'h00F0F);
      chk("R6 both held a_out", a_out, 18'h3C003);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_drive();
      t_transparent();
      t_load();
      t_enable();
      t_pass_ignores();
      t_off_updates();
      t_reverse_and_both();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule